// File: doc/BRIEF.md
# Dual Circular-Buffer Address Generator

This block supplies operand addresses for two memory ports at once. It holds two identical generator units. Each unit keeps a small file of index pointers, a file of signed step values, and a length and a base for each pointer. An access picks one pointer and one step register. The unit then puts the pointer's current value on its address output in the same cycle. On the next clock edge it replaces the pointer with the pointer plus the step. If the pointer has a nonzero length, the new value is folded back into the circular window `[base, base+length)`.

Software-style setup comes through a per-unit load port, which writes one pointer, step or length per cycle. Each access port is a valid/ready stream. A unit accepts an access (`acc_valid && acc_ready`) only in a cycle in which its own load port is idle. A load therefore back-pressures that unit's access for the cycle it occupies. The address output always shows the selected pointer, so a stalled requester can keep its request up and use the address once ready returns. A request held without ready must stay unchanged. The two units never stall each other.

Top module: `dual_agu`

## Requirements
- R1: While `rst` is high, every pointer, step, length and base of both units is cleared to 0, so every selected address reads 0 once reset is released.
- R2: A load (`ld_valid` high) writes `ld_data` into register `ld_idx` of the class given by `ld_kind`: 0 = pointer (the base of that pointer is loaded with the same value), 1 = step, 2 = length, 3 = no register is changed. The written value is visible from the next cycle.
- R3: `acc_addr` equals the current value of the pointer chosen by `acc_ptr`, in the same cycle, before any update.
- R4: An accepted access updates only the selected pointer, and the new value is visible in the following cycle. The other pointers, and the other unit, are unaffected.
- R5: With length 0, the updated pointer is the old pointer plus the step, with the 14-bit step read as two's complement and the result taken modulo 2^14.
- R6: With a nonzero length L and base B, a sum at or above B+L is reduced by L.
- R7: With a nonzero length L and base B, a sum below B is increased by L (the step magnitude must be less than L).
- R8: `acc_ready` is low exactly in cycles where that unit's `ld_valid` is high. An access that is not accepted leaves every pointer unchanged.
- R9: Both units accept accesses and loads in the same cycle and operate independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_valid | input | 2 | Per-unit load strobe |
| ld_kind | input | 2x2 | Per-unit register class (0 pointer, 1 step, 2 length, 3 none) |
| ld_idx | input | 2x2 | Per-unit register index |
| ld_data | input | 2x14 | Per-unit load value |
| acc_valid | input | 2 | Per-unit access request |
| acc_ready | output | 2 | Per-unit access acceptance |
| acc_ptr | input | 2x2 | Per-unit pointer select |
| acc_mod | input | 2x2 | Per-unit step register select |
| acc_addr | output | 2x14 | Per-unit pre-update address |

## Verification
The hardest state to reach is a pointer sitting at the edge of its window while a step of the right sign moves it across that edge. It is harder still when a load is stalling the same unit in that cycle, or when a step register is rewritten between two wrapping accesses. The stimulus first uses directed loads to build windows of different lengths. It then walks pointers across both edges with steps of each sign. Finally it runs a long mixed phase on both units at once, with random pointer reloads, step rewrites, no-op loads and stalls. A behavioural model predicts every address and ready value in every cycle.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    LK_PTR  = 2'd0,
    LK_MOD  = 2'd1,
    LK_LEN  = 2'd2,
    LK_NONE = 2'd3
  } ld_kind_e;
endpackage

// File: rtl/agu_wrap.sv
module agu_wrap #(
  parameter int AW = 14
) (
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] step,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] len,
  output logic [AW-1:0] nxt
);
  localparam int SW = AW + 2;

  logic signed [SW-1:0] sum, lo, ln, hi, res;

  always_comb begin
    sum = $signed({2'b00, cur}) + $signed({{2{step[AW-1]}}, step});
    lo  = $signed({2'b00, base});
    ln  = $signed({2'b00, len});
    hi  = lo + ln;
    if (len == '0)     res = sum;
    else if (sum >= hi) res = sum - ln;
    else if (sum < lo)  res = sum + ln;
    else                res = sum;
    nxt = res[AW-1:0];
  end
endmodule

// File: rtl/agu_unit.sv
module agu_unit
  import agu_pkg::*;
#(
  parameter int AW   = 14,
  parameter int NPTR = 4,
  localparam int IW  = (NPTR > 1) ? $clog2(NPTR) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_valid,
  input  logic [1:0]    ld_kind,
  input  logic [IW-1:0] ld_idx,
  input  logic [AW-1:0] ld_data,
  input  logic          acc_valid,
  output logic          acc_ready,
  input  logic [IW-1:0] acc_ptr,
  input  logic [IW-1:0] acc_mod,
  output logic [AW-1:0] acc_addr
);
  logic [NPTR-1:0][AW-1:0] ptr_q, step_q, len_q, base_q;
  logic [AW-1:0] nxt;
  logic          fire;
  ld_kind_e      kind;

  assign kind      = ld_kind_e'(ld_kind);
  assign acc_ready = ~ld_valid;
  assign fire      = acc_valid & acc_ready;
  assign acc_addr  = ptr_q[acc_ptr];

  agu_wrap #(.AW(AW)) u_wrap (
    .cur  (acc_addr),
    .step (step_q[acc_mod]),
    .base (base_q[acc_ptr]),
    .len  (len_q[acc_ptr]),
    .nxt  (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      step_q <= '0;
      len_q  <= '0;
      base_q <= '0;
    end else if (ld_valid) begin
      case (kind)
        LK_PTR: begin
          ptr_q[ld_idx]  <= ld_data;
          base_q[ld_idx] <= ld_data;
        end
        LK_MOD:  step_q[ld_idx] <= ld_data;
        LK_LEN:  len_q[ld_idx]  <= ld_data;
        default: ;
      endcase
    end else if (fire) begin
      ptr_q[acc_ptr] <= nxt;
    end
  end

  // Checks
  logic [AW-1:0] step_mag;
  logic          in_win;
  assign step_mag = step_q[acc_mod][AW-1] ? (~step_q[acc_mod] + 1'b1) : step_q[acc_mod];
  assign in_win   = (acc_addr >= base_q[acc_ptr]) &&
                    ((acc_addr - base_q[acc_ptr]) < len_q[acc_ptr]) &&
                    ({1'b0, base_q[acc_ptr]} + {1'b0, len_q[acc_ptr]} <= (1 << AW));

  p_ptr_load_r2: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && kind == LK_PTR) |=>
      (ptr_q[$past(ld_idx)] == $past(ld_data)) && (base_q[$past(ld_idx)] == $past(ld_data)));

  p_linear_step_r5: assert property (@(posedge clk) disable iff (rst)
    (fire && len_q[acc_ptr] == '0) |=>
      ptr_q[$past(acc_ptr)] == $past(acc_addr + step_q[acc_mod]));

  p_stay_in_window_r6: assert property (@(posedge clk) disable iff (rst)
    (fire && len_q[acc_ptr] != '0 && in_win && step_mag < len_q[acc_ptr]) |=>
      (ptr_q[$past(acc_ptr)] >= base_q[$past(acc_ptr)]) &&
      ((ptr_q[$past(acc_ptr)] - base_q[$past(acc_ptr)]) < len_q[$past(acc_ptr)]));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!acc_valid && !ld_valid) |=> $stable(ptr_q));

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && ld_valid && kind != LK_PTR) |=> $stable(ptr_q));
endmodule

// File: rtl/dual_agu.sv
module dual_agu #(
  parameter int AW   = 14,
  parameter int NPTR = 4,
  localparam int IW  = (NPTR > 1) ? $clog2(NPTR) : 1,
  localparam int NU  = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NU-1:0]          ld_valid,
  input  logic [NU-1:0][1:0]     ld_kind,
  input  logic [NU-1:0][IW-1:0]  ld_idx,
  input  logic [NU-1:0][AW-1:0]  ld_data,
  input  logic [NU-1:0]          acc_valid,
  output logic [NU-1:0]          acc_ready,
  input  logic [NU-1:0][IW-1:0]  acc_ptr,
  input  logic [NU-1:0][IW-1:0]  acc_mod,
  output logic [NU-1:0][AW-1:0]  acc_addr
);
  for (genvar g = 0; g < NU; g++) begin : g_unit
    agu_unit #(.AW(AW), .NPTR(NPTR)) u_agu (
      .clk       (clk),
      .rst       (rst),
      .ld_valid  (ld_valid[g]),
      .ld_kind   (ld_kind[g]),
      .ld_idx    (ld_idx[g]),
      .ld_data   (ld_data[g]),
      .acc_valid (acc_valid[g]),
      .acc_ready (acc_ready[g]),
      .acc_ptr   (acc_ptr[g]),
      .acc_mod   (acc_mod[g]),
      .acc_addr  (acc_addr[g])
    );
  end
endmodule

// File: tb/dual_agu_test.sv
module dual_agu_test;
  logic             clk = 1'b0;
  logic             rst;
  logic [1:0]       ld_valid, acc_valid, acc_ready;
  logic [1:0][1:0]  ld_kind, ld_idx, acc_ptr, acc_mod;
  logic [1:0][13:0] ld_data, acc_addr;

  always #4 clk = ~clk;

  dual_agu uut (.*);

  int mptr[2][4], mstep[2][4], mlen[2][4], mbase[2][4];
  int n_chk = 0, n_bad = 0, cyc = 0;
  string tag = "R1";

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 60000) begin
      n_bad++;
      $display("FAIL watchdog %s: got hang expected completion", tag);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  function automatic int nextp(int p, int m, int b, int l);
    int s;
    if (m >= 8192) m -= 16384;
    s = p + m;
    if (l != 0) begin
      if (s >= b + l) s -= l;
      else if (s < b) s += l;
    end
    return s & 16383;
  endfunction

  task automatic check();
    for (int u = 0; u < 2; u++) begin
      n_chk++;
      if (acc_ready[u] !== !ld_valid[u]) begin
        n_bad++;
        $display("FAIL %s/R8 unit%0d ready: got %b expected %b", tag, u, acc_ready[u], !ld_valid[u]);
      end
      n_chk++;
      if (int'(acc_addr[u]) != mptr[u][acc_ptr[u]]) begin
        n_bad++;
        $display("FAIL %s/R3 unit%0d ptr%0d addr: got %0d expected %0d",
                 tag, u, acc_ptr[u], acc_addr[u], mptr[u][acc_ptr[u]]);
      end
    end
  endtask

  task automatic step();
    #2 check();
    @(posedge clk);
    for (int u = 0; u < 2; u++) begin
      if (rst) begin
        for (int i = 0; i < 4; i++) begin
          mptr[u][i] = 0; mstep[u][i] = 0; mlen[u][i] = 0; mbase[u][i] = 0;
        end
      end else if (ld_valid[u]) begin
        case (ld_kind[u])
          2'd0: begin mptr[u][ld_idx[u]] = ld_data[u]; mbase[u][ld_idx[u]] = ld_data[u]; end
          2'd1: mstep[u][ld_idx[u]] = ld_data[u];
          2'd2: mlen[u][ld_idx[u]]  = ld_data[u];
          default: ;
        endcase
      end else if (acc_valid[u]) begin
        mptr[u][acc_ptr[u]] = nextp(mptr[u][acc_ptr[u]], mstep[u][acc_mod[u]],
                                    mbase[u][acc_ptr[u]], mlen[u][acc_ptr[u]]);
      end
    end
    @(negedge clk);
  endtask

  task automatic idle();
    ld_valid = '0; acc_valid = '0;
  endtask

  task automatic ld(int u, int k, int i, int d);
    idle();
    ld_valid[u] = 1'b1; ld_kind[u] = 2'(k); ld_idx[u] = 2'(i); ld_data[u] = 14'(d);
    step();
  endtask

  task automatic acc(int u, int p, int m, int n);
    for (int k = 0; k < n; k++) begin
      idle();
      acc_valid[u] = 1'b1; acc_ptr[u] = 2'(p); acc_mod[u] = 2'(m);
      step();
    end
  endtask

  task automatic peek(int u, int p);
    idle(); acc_ptr[u] = 2'(p); step();
  endtask

  initial begin
    rst = 1'b1; idle();
    ld_kind = '0; ld_idx = '0; ld_data = '0; acc_ptr = '0; acc_mod = '0;
    @(negedge clk);
    tag = "R1";
    for (int k = 0; k < 3; k++) step();
    rst = 1'b0;
    for (int p = 0; p < 4; p++) begin peek(0, p); peek(1, p); end

    tag = "R2";
    for (int i = 0; i < 4; i++) begin
      ld(0, 0, i, 10 + 10 * i);
      ld(1, 0, i, 200 + 7 * i);
    end
    ld(0, 1, 0, 1); ld(0, 1, 1, 3); ld(0, 1, 2, 16383); ld(0, 1, 3, 16381);
    ld(1, 1, 0, 2); ld(1, 1, 1, 16382);
    ld(0, 3, 0, 999);
    for (int p = 0; p < 4; p++) begin peek(0, p); peek(1, p); end

    tag = "R4";
    acc(0, 0, 0, 3);
    for (int p = 0; p < 4; p++) peek(0, p);

    tag = "R5";
    ld(0, 0, 3, 1);
    acc(0, 3, 3, 2);
    acc(0, 3, 1, 3);
    peek(0, 3);

    tag = "R6";
    ld(0, 2, 1, 8);
    acc(0, 1, 1, 6);
    peek(0, 1);

    tag = "R7";
    ld(0, 2, 2, 5);
    acc(0, 2, 2, 7);
    ld(0, 1, 2, 16381);
    acc(0, 2, 2, 4);
    peek(0, 2);

    tag = "R8";
    idle();
    acc_valid = 2'b11; acc_ptr[0] = 2'd0; acc_mod[0] = 2'd0; acc_ptr[1] = 2'd0; acc_mod[1] = 2'd0;
    ld_valid[0] = 1'b1; ld_kind[0] = 2'd3; step();
    ld_valid[0] = 1'b1; ld_kind[0] = 2'd1; ld_idx[0] = 2'd3; ld_data[0] = 14'd2; step();
    ld_valid[0] = 1'b0; step();
    peek(0, 0); peek(1, 0);

    tag = "R9";
    for (int u = 0; u < 2; u++)
      for (int i = 0; i < 4; i++) begin
        ld(u, 2, i, (i == 3) ? 0 : 5 + 3 * i + u);
        ld(u, 1, i, (i % 2 == 0) ? (1 + i / 2) : 16384 - (1 + i / 2));
      end
    for (int k = 0; k < 4000; k++) begin
      idle();
      for (int u = 0; u < 2; u++) begin
        int r = $urandom_range(0, 19);
        acc_valid[u] = 1'b1;
        acc_ptr[u]   = 2'($urandom_range(0, 3));
        acc_mod[u]   = 2'($urandom_range(0, 3));
        if (r == 0) begin
          ld_valid[u] = 1'b1; ld_kind[u] = 2'd0;
          ld_idx[u] = 2'($urandom_range(0, 3)); ld_data[u] = 14'($urandom_range(0, 16000));
        end else if (r == 1) begin
          ld_valid[u] = 1'b1; ld_kind[u] = 2'd1; ld_idx[u] = 2'($urandom_range(0, 3));
          ld_data[u] = 14'(16384 + int'($urandom_range(0, 4)) - 2);
        end else if (r == 2) begin
          ld_valid[u] = 1'b1; ld_kind[u] = 2'd3;
          ld_idx[u] = 2'($urandom_range(0, 3)); ld_data[u] = 14'($urandom);
        end else if (r == 3) begin
          acc_valid[u] = 1'b0;
        end
      end
      step();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule